// File: doc/BRIEF.md
# Programmable I/O Access Trap

This block watches I/O accesses and raises a system-management interrupt request when an access falls inside one of three programmable address windows. Each trap has a base address, a control word (window size as a power of two, plus separate read and write qualifiers) and an enable bit held in a shared enable register. An access that lands in an enabled, qualifying window records a hit. The hit sets a per-trap detail status bit and a single summary status bit that all three traps share.

Software configures the traps through a small register-write port, using a select code and a data word. It finds out which trap fired by reading the detail status word. It acknowledges a trap by writing ones to the status bits it wants to clear. The interrupt request stays high as long as any status bit remains set. The block does not stall or block the trapped bus cycle, and it implements no bus protocol.

Top module: `io_trap_unit`

## Requirements
- R1: While `rst` is high, the next clock edge clears the enable register, every base and control register and every status bit, and `smi_req` reads 0.
- R2: A write with `reg_sel`=0 loads the enable register. Trap 1 uses bit 4, trap 2 uses bit 5 and trap 3 uses bit 6 (1 = enabled, 0 = disabled). All other bits of `en_q` always read 0.
- R3: `reg_sel` 1, 2 and 3 load the 16-bit base of traps 1, 2 and 3. `reg_sel` 4, 5 and 6 load their control words. Control bits [3:0] give n, and the trap window is the 2^n bytes from `base & ~(2^n-1)`. An address matches when `(addr ^ base) >> n` is zero.
- R4: Control bit 4 lets a read (`io_write`=0) match. Control bit 5 lets a write (`io_write`=1) match. An access whose direction bit is clear does not hit.
- R5: A trap whose enable bit is 0 never hits, even for an access inside its window.
- R6: On the clock edge that samples a hit on trap k (k = 1, 2, 3), bit k+1 of `sub_sts` (bits 2, 3, 4) and bit 9 of `top_sts` become 1. They are visible right after that edge.
- R7: One access that matches several enabled traps sets the detail bit of every trap it matches.
- R8: A write with `reg_sel`=8 clears each of `sub_sts` bits 2..4 whose data bit is 1. A write with `reg_sel`=7 clears `top_sts` bit 9 when data bit 9 is 1. Data bits that are 0 leave status unchanged.
- R9: `smi_req` is 1 exactly while any bit of `top_sts` or `sub_sts` is 1. In particular, it stays 1 after only the summary bit is cleared.
- R10: When a hit and a clear of the same status bit fall on the same edge, the bit ends up set.
- R11: With `io_strobe` low, address and direction inputs change no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_strobe | input | 1 | One-cycle I/O access qualifier |
| io_addr | input | 16 | I/O access address |
| io_write | input | 1 | 1 = write access, 0 = read access |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select code (see R2, R3, R8) |
| reg_wdata | input | 16 | Register write data |
| en_q | output | 8 | Enable register readback |
| top_sts | output | 16 | Summary status word, bit 9 shared by all traps |
| sub_sts | output | 8 | Detail status word, bits 2..4 for traps 1..3 |
| smi_req | output | 1 | Interrupt request, high while any status bit is set |

## Verification
A corrupted window mask or a wrong direction qualifier makes a detail bit appear or stay missing one cycle after the access. The vector table probes addresses on both sides of each window edge and in both directions, so such a fault shows up there. A stale status register shows up as an `smi_req` that does not drop after a full clear, or that drops while a detail bit is still pending. The bench samples both cases on the cycle right after the clearing write. A wrong bit ordering in the set-versus-clear merge is caught on the single edge where both happen together.

// File: rtl/io_trap_pkg.sv
package io_trap_pkg;

    localparam int ADDR_W   = 16;
    localparam int N_TRAP   = 3;
    localparam int DATA_W   = 16;
    localparam int EN_W     = 8;
    localparam int EN_LSB   = 4;
    localparam int TOP_W    = 16;
    localparam int TOP_BIT  = 9;
    localparam int SUB_W    = 8;
    localparam int SUB_LSB  = 2;
    localparam int SIZE_W   = 4;

    typedef enum logic [3:0] {
        SEL_ENABLE  = 4'd0,
        SEL_BASE1   = 4'd1,
        SEL_BASE2   = 4'd2,
        SEL_BASE3   = 4'd3,
        SEL_CTRL1   = 4'd4,
        SEL_CTRL2   = 4'd5,
        SEL_CTRL3   = 4'd6,
        SEL_CLR_TOP = 4'd7,
        SEL_CLR_SUB = 4'd8
    } reg_sel_e;

    typedef struct packed {
        logic              wr_ok;
        logic              rd_ok;
        logic [SIZE_W-1:0] size;
    } trap_ctrl_t;

    typedef struct packed {
        logic              strobe;
        logic              write;
        logic [ADDR_W-1:0] addr;
    } io_acc_t;

    function automatic logic [ADDR_W-1:0] win_mask(input logic [SIZE_W-1:0] n);
        logic [ADDR_W-1:0] m;
        m = '1;
        for (int i = 0; i < ADDR_W; i++) begin
            if (i < int'(n)) m[i] = 1'b0;
        end
        return m;
    endfunction

    function automatic trap_ctrl_t unpack_ctrl(input logic [DATA_W-1:0] d);
        trap_ctrl_t c;
        c.size  = d[SIZE_W-1:0];
        c.rd_ok = d[SIZE_W];
        c.wr_ok = d[SIZE_W+1];
        return c;
    endfunction

endpackage

// File: rtl/io_trap_regs.sv
module io_trap_regs
    import io_trap_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           reg_we,
    input  logic [3:0]                     reg_sel,
    input  logic [DATA_W-1:0]              reg_wdata,
    output logic [EN_W-1:0]                en_q,
    output logic [N_TRAP-1:0][ADDR_W-1:0]  base_q,
    output trap_ctrl_t [N_TRAP-1:0]        ctrl_q
);
    localparam logic [EN_W-1:0] EN_MASK = EN_W'(((1 << N_TRAP) - 1) << EN_LSB);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (reg_we && reg_sel == SEL_ENABLE) begin
            en_q <= reg_wdata[EN_W-1:0] & EN_MASK;
        end
    end

    for (genvar k = 0; k < N_TRAP; k++) begin : g_trap_cfg
        localparam logic [3:0] BASE_SEL = 4'(int'(SEL_BASE1) + k);
        localparam logic [3:0] CTRL_SEL = 4'(int'(SEL_CTRL1) + k);
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[k] <= '0;
                ctrl_q[k] <= '0;
            end else if (reg_we) begin
                if (reg_sel == BASE_SEL) base_q[k] <= reg_wdata[ADDR_W-1:0];
                if (reg_sel == CTRL_SEL) ctrl_q[k] <= unpack_ctrl(reg_wdata);
            end
        end
    end

    // R2
    en_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == SEL_ENABLE) |=> (en_q == ($past(reg_wdata[EN_W-1:0]) & EN_MASK)));

endmodule

// File: rtl/io_trap_window.sv
module io_trap_window
    import io_trap_pkg::*;
(
    input  logic              enable,
    input  logic [ADDR_W-1:0] base,
    input  trap_ctrl_t        ctrl,
    input  io_acc_t           acc,
    output logic              hit
);
    logic [ADDR_W-1:0] mask;
    logic              in_win;
    logic              dir_ok;

    always_comb begin
        mask   = win_mask(ctrl.size);
        in_win = ((acc.addr ^ base) & mask) == '0;
        dir_ok = acc.write ? ctrl.wr_ok : ctrl.rd_ok;
        hit    = acc.strobe && enable && in_win && dir_ok;
    end

endmodule

// File: rtl/io_trap_status.sv
module io_trap_status
    import io_trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TRAP-1:0] hits,
    input  logic              clr_top,
    input  logic [N_TRAP-1:0] clr_sub,
    output logic [N_TRAP-1:0] sub_q,
    output logic              top_q,
    output logic              smi
);
    logic [N_TRAP-1:0] sub_d;
    logic              top_d;

    always_comb begin
        sub_d = (sub_q & ~clr_sub) | hits;
        top_d = (top_q & ~clr_top) | (|hits);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= '0;
            top_q <= 1'b0;
        end else begin
            sub_q <= sub_d;
            top_q <= top_d;
        end
    end

    assign smi = top_q | (|sub_q);

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (sub_q == '0 && !top_q && !smi));

    // R6 R7 R10
    set_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (hits != '0) |=> ((sub_q & $past(hits)) == $past(hits) && top_q));

    // R8
    clr_sub_chk: assert property (@(posedge clk) disable iff (rst)
        ((clr_sub & ~hits) != '0) |=> ((sub_q & $past(clr_sub & ~hits)) == '0));

    // R8
    clr_top_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_top && hits == '0) |=> !top_q);

endmodule

// File: rtl/io_trap_unit.sv
module io_trap_unit
    import io_trap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               io_strobe,
    input  logic [ADDR_W-1:0]  io_addr,
    input  logic               io_write,
    input  logic               reg_we,
    input  logic [3:0]         reg_sel,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [EN_W-1:0]    en_q,
    output logic [TOP_W-1:0]   top_sts,
    output logic [SUB_W-1:0]   sub_sts,
    output logic               smi_req
);
    logic [N_TRAP-1:0][ADDR_W-1:0] base_q;
    trap_ctrl_t [N_TRAP-1:0]       ctrl_q;
    logic [N_TRAP-1:0]             hits;
    logic [N_TRAP-1:0]             sub_q;
    logic                          top_q;
    logic                          clr_top;
    logic [N_TRAP-1:0]             clr_sub;
    io_acc_t                       acc;

    assign acc = '{strobe: io_strobe, write: io_write, addr: io_addr};

    io_trap_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .en_q      (en_q),
        .base_q    (base_q),
        .ctrl_q    (ctrl_q)
    );

    for (genvar k = 0; k < N_TRAP; k++) begin : g_win
        io_trap_window u_win (
            .enable (en_q[EN_LSB+k]),
            .base   (base_q[k]),
            .ctrl   (ctrl_q[k]),
            .acc    (acc),
            .hit    (hits[k])
        );
    end

    assign clr_top = reg_we && reg_sel == SEL_CLR_TOP && reg_wdata[TOP_BIT];
    assign clr_sub = (reg_we && reg_sel == SEL_CLR_SUB) ? reg_wdata[SUB_LSB +: N_TRAP] : '0;

    io_trap_status u_sts (
        .clk     (clk),
        .rst     (rst),
        .hits    (hits),
        .clr_top (clr_top),
        .clr_sub (clr_sub),
        .sub_q   (sub_q),
        .top_q   (top_q),
        .smi     (smi_req)
    );

    always_comb begin
        top_sts          = '0;
        top_sts[TOP_BIT] = top_q;
        sub_sts          = '0;
        sub_sts[SUB_LSB +: N_TRAP] = sub_q;
    end

    // R11
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!io_strobe && !reg_we) |=> ($stable(sub_sts) && $stable(top_sts)));

    // R2
    en_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> (en_q[EN_LSB-1:0] == '0 && en_q[EN_W-1] == 1'b0));

endmodule

// File: tb/tb_io_trap_unit.sv
module tb_io_trap_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_strobe = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_write = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_sel = '0;
    logic [15:0] reg_wdata = '0;
    logic [7:0]  en_q;
    logic [15:0] top_sts;
    logic [7:0]  sub_sts;
    logic        smi_req;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    io_trap_unit dut (
        .clk(clk), .rst(rst), .io_strobe(io_strobe), .io_addr(io_addr),
        .io_write(io_write), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .en_q(en_q), .top_sts(top_sts),
        .sub_sts(sub_sts), .smi_req(smi_req)
    );

    // {addr[15:0], write, expected traps 3..1}
    localparam int NVEC = 8;
    localparam logic [19:0] VEC [NVEC] = '{
        {16'h0400, 1'b0, 3'b001},
        {16'h0407, 1'b1, 3'b011},
        {16'h0405, 1'b0, 3'b001},
        {16'h0408, 1'b0, 3'b000},
        {16'h10FF, 1'b0, 3'b100},
        {16'h1100, 1'b0, 3'b000},
        {16'h1010, 1'b1, 3'b000},
        {16'h03FF, 1'b1, 3'b000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] sel, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic io_acc(input logic [15:0] a, input logic wr);
        @(negedge clk);
        io_strobe = 1'b1; io_addr = a; io_write = wr;
        @(negedge clk);
        io_strobe = 1'b0;
    endtask

    task automatic clear_all();
        reg_wr(4'd8, 16'h001C);
        reg_wr(4'd7, 16'h0200);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 en", 32'(en_q), 32'h00);
        check("R1 sts", {16'(top_sts), 8'(sub_sts), 7'd0, smi_req}, 32'h0);

        // R2 only bits 6:4 of enable stick
        reg_wr(4'd0, 16'h00FF);
        check("R2 en", 32'(en_q), 32'h70);

        // R3 R4 configuration
        reg_wr(4'd1, 16'h0400); reg_wr(4'd4, 16'h0033);
        reg_wr(4'd2, 16'h0404); reg_wr(4'd5, 16'h0022);
        reg_wr(4'd3, 16'h1000); reg_wr(4'd6, 16'h0018);

        // R3 R4 R6 R7 R9 table walk
        for (int i = 0; i < NVEC; i++) begin
            clear_all();
            io_acc(VEC[i][19:4], VEC[i][3]);
            check("R3/R4/R7 sub", 32'(sub_sts), 32'({VEC[i][2:0], 2'b00}));
            check("R6 top", 32'(top_sts), (VEC[i][2:0] != 0) ? 32'h0200 : 32'h0);
            check("R9 smi", 32'(smi_req), 32'(VEC[i][2:0] != 0));
        end

        // R11 no strobe, no effect
        clear_all();
        @(negedge clk);
        io_addr = 16'h0400; io_write = 1'b0;
        @(negedge clk);
        check("R11 sub", 32'(sub_sts), 32'h0);
        check("R11 smi", 32'(smi_req), 32'h0);

        // R5 disabled trap 1
        reg_wr(4'd0, 16'h0060);
        io_acc(16'h0400, 1'b0);
        check("R5 sub", 32'(sub_sts), 32'h0);
        check("R5 top", 32'(top_sts), 32'h0);
        reg_wr(4'd0, 16'h0070);

        // R8 partial clear and zero bits
        io_acc(16'h0406, 1'b1);
        check("R7 both", 32'(sub_sts), 32'h0C);
        reg_wr(4'd8, 16'h0000);
        check("R8 zero write", 32'(sub_sts), 32'h0C);
        reg_wr(4'd8, 16'h0004);
        check("R8 partial", 32'(sub_sts), 32'h08);
        reg_wr(4'd7, 16'h0000);
        check("R8 top zero write", 32'(top_sts), 32'h0200);
        // R9 top cleared but detail pending keeps smi
        reg_wr(4'd7, 16'h0200);
        check("R8 top clr", 32'(top_sts), 32'h0);
        check("R9 smi held", 32'(smi_req), 32'h1);
        reg_wr(4'd8, 16'h0008);
        check("R9 smi drop", 32'(smi_req), 32'h0);

        // R10 set wins over simultaneous clear
        io_acc(16'h0401, 1'b0);
        @(negedge clk);
        io_strobe = 1'b1; io_addr = 16'h0401; io_write = 1'b0;
        reg_we = 1'b1; reg_sel = 4'd8; reg_wdata = 16'h0004;
        @(negedge clk);
        io_strobe = 1'b0; reg_we = 1'b0;
        check("R10 sub", 32'(sub_sts), 32'h04);

        // R3 single-byte window n=0
        clear_all();
        reg_wr(4'd3, 16'h2000); reg_wr(4'd6, 16'h0010);
        io_acc(16'h2001, 1'b0);
        check("R3 n0 miss", 32'(sub_sts), 32'h0);
        io_acc(16'h2000, 1'b0);
        check("R3 n0 hit", 32'(sub_sts), 32'h10);

        // R1 reset clears status and config
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 re-reset", {16'(top_sts), 8'(sub_sts), en_q}, 32'h0);
        check("R1 smi", 32'(smi_req), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule